// File: doc/BRIEF.md
# NRZI Receive Decoder and Five-Bit Symbol Deserializer

This block is the receive datapath of a 100BASE-X style fiber physical layer, sitting behind clock and data recovery. It runs on the recovered bit clock (nominally 125 MHz). On each bit clock edge it samples one NRZI line bit and turns it back into NRZ by comparing it with the bit sampled on the edge before. It then gathers five decoded bits into a code-group. It also divides the bit clock by five to make a 25 MHz receive symbol clock. That symbol clock is produced in the bit clock domain, so it keeps a fixed phase against the bit clock. Each symbol is presented on the falling edge of the symbol clock, so logic downstream can capture it on the rising edge.

A loopback select picks the source of the serial stream. When the select is low, the transmit-side serial stream is decoded and the line input is ignored. When the select is high, the line input is decoded. A power-enable input stops the block when low. While it is low the symbol output is zero and the symbol clock is low. When power returns, the block starts again from the same phase it has after reset.

The core is a five-state slot machine with states SLOT0, SLOT1, SLOT2, SLOT3 and SLOT4, one state per bit of a code-group. It has three transitions. ADVANCE moves SLOTn to SLOTn+1 on an enabled edge. WRAP moves SLOT4 to SLOT0 on an enabled edge and completes a symbol. HALT forces any state to SLOT0 while power is disabled. Asynchronous reset also puts the machine in SLOT0.

Top module: `nrzi_symbol_rx`

## Requirements
- R1: Each decoded bit is the XOR of the source bit sampled on the current bit clock edge and the source bit sampled on the previous edge. The stored previous bit is 0 after reset and after power-down.
- R2: Within a code-group, the bit decoded first lands in `sym_data[0]` and the bit decoded fifth lands in `sym_data[4]`.
- R3: `sym_data` is updated only on the edge that decodes the fifth bit of a group, and it holds its value on the other four edges. The first group starts at the first enabled edge after reset or power-up.
- R4: `sym_clk` is registered from the bit clock and has a period of five bit clocks. It is high for three bit clocks and low for two. It rises on the edge that decodes the second bit of a group and falls on the same edge on which `sym_data` updates.
- R5: With `loop_n` low, the stream on `loop_nrzi` is decoded, and activity on `line_nrzi` has no effect on `sym_data`.
- R6: With `loop_n` high, the stream on `line_nrzi` is decoded, and activity on `loop_nrzi` has no effect on `sym_data`.
- R7: One edge after `pwr_en` is sampled low, `sym_data` is 0 and `sym_clk` is low, and both stay that way while `pwr_en` stays low. The first enabled edge after that starts a new group in SLOT0.
- R8: While `rst_n` is low, `sym_data` is 0 and `sym_clk` is low, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered serial bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_en | input | 1 | Block enable; low stops the block |
| loop_n | input | 1 | Source select; low selects `loop_nrzi` |
| line_nrzi | input | 1 | Serial NRZI bit from the line |
| loop_nrzi | input | 1 | Serial NRZI bit from the transmit path |
| sym_clk | output | 1 | Symbol clock, bit clock divided by five |
| sym_data | output | 5 | Received code-group, bit 0 decoded first |

## Verification
A wrong slot state moves the group boundary. At the ports this shows up within one symbol period: `sym_clk` falls on the wrong edge, and every later symbol comes out rotated. A stuck or stale previous-bit register inverts the decoded bits where the stream has a transition. That corrupts the very next symbol, and the error is clearest on all-ones and all-zeros groups. A source select that leaks through, or power gating that fails, shows up in the first symbol formed while the other input is toggling. It also shows up on the first edge after `pwr_en` falls.

// File: rtl/rx_sym_pkg.sv
package rx_sym_pkg;
    localparam int SYM_W       = 5;
    localparam int SLOT_W      = $clog2(SYM_W);
    localparam int CLK_HI_SLOT = 2;

    typedef enum logic [SLOT_W-1:0] {
        SLOT0 = 3'd0,
        SLOT1 = 3'd1,
        SLOT2 = 3'd2,
        SLOT3 = 3'd3,
        SLOT4 = 3'd4
    } slot_t;
endpackage

// File: rtl/rx_src_sel.sv
module rx_src_sel (
    input  logic line_nrzi,
    input  logic loop_nrzi,
    input  logic loop_n,
    input  logic pwr_en,
    output logic src_bit
);
    always_comb begin
        if (!pwr_en)
            src_bit = 1'b0;
        else if (loop_n)
            src_bit = line_nrzi;
        else
            src_bit = loop_nrzi;
    end
endmodule

// File: rtl/rx_nrzi_dec.sv
module rx_nrzi_dec (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_en,
    input  logic src_bit,
    output logic nrz_bit
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prev_q <= 1'b0;
        else if (!pwr_en)
            prev_q <= 1'b0;
        else
            prev_q <= src_bit;
    end

    // a level change between two bit times encodes a one
    assign nrz_bit = src_bit ^ prev_q;
endmodule

// File: rtl/rx_slot_fsm.sv
module rx_slot_fsm
    import rx_sym_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_en,
    output logic last_slot,
    output logic sym_clk
);
    slot_t state_q;
    slot_t state_d;

    always_comb begin
        state_d = state_q;
        if (!pwr_en) begin
            state_d = SLOT0;              // HALT
        end else begin
            unique case (state_q)
                SLOT0:   state_d = SLOT1; // ADVANCE
                SLOT1:   state_d = SLOT2;
                SLOT2:   state_d = SLOT3;
                SLOT3:   state_d = SLOT4;
                SLOT4:   state_d = SLOT0; // WRAP
                default: state_d = SLOT0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= SLOT0;
        else
            state_q <= state_d;
    end

    // output process: clock level is a registered decode of the next slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sym_clk <= 1'b0;
        else
            sym_clk <= pwr_en && (state_d >= slot_t'(CLK_HI_SLOT));
    end

    assign last_slot = pwr_en && (state_q == SLOT4);
endmodule

// File: rtl/rx_sym_gather.sv
module rx_sym_gather #(
    parameter int SYM_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_en,
    input  logic             nrz_bit,
    input  logic             last_slot,
    output logic [SYM_W-1:0] sym_data
);
    logic [SYM_W-1:0] shift_q;
    logic [SYM_W-1:0] shift_d;

    // newest bit enters at the top so the oldest ends up in bit 0
    assign shift_d = {nrz_bit, shift_q[SYM_W-1:1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q  <= '0;
            sym_data <= '0;
        end else if (!pwr_en) begin
            shift_q  <= '0;
            sym_data <= '0;
        end else begin
            shift_q <= shift_d;
            if (last_slot)
                sym_data <= shift_d;
        end
    end
endmodule

// File: rtl/nrzi_symbol_rx.sv
module nrzi_symbol_rx
    import rx_sym_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_en,
    input  logic             loop_n,
    input  logic             line_nrzi,
    input  logic             loop_nrzi,
    output logic             sym_clk,
    output logic [SYM_W-1:0] sym_data
);
    logic src_bit;
    logic nrz_bit;
    logic last_slot;

    rx_src_sel i_src (
        .line_nrzi (line_nrzi),
        .loop_nrzi (loop_nrzi),
        .loop_n    (loop_n),
        .pwr_en    (pwr_en),
        .src_bit   (src_bit)
    );

    rx_nrzi_dec i_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwr_en  (pwr_en),
        .src_bit (src_bit),
        .nrz_bit (nrz_bit)
    );

    rx_slot_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_en    (pwr_en),
        .last_slot (last_slot),
        .sym_clk   (sym_clk)
    );

    rx_sym_gather #(.SYM_W(SYM_W)) i_gather (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_en    (pwr_en),
        .nrz_bit   (nrz_bit),
        .last_slot (last_slot),
        .sym_data  (sym_data)
    );
endmodule

// File: rtl/nrzi_symbol_rx_chk.sv
module nrzi_symbol_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_en,
    input logic       sym_clk,
    input logic [4:0] sym_data
);
    assert_update_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pwr_en) && pwr_en && (sym_data != $past(sym_data))) |-> $fell(sym_clk));

    assert_low_two_R4: assert property (@(posedge clk) disable iff (!rst_n || !pwr_en)
        $fell(sym_clk) |=> !sym_clk);

    assert_high_three_R4: assert property (@(posedge clk) disable iff (!rst_n || !pwr_en)
        $rose(sym_clk) |=> sym_clk ##1 sym_clk);

    assert_pd_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |=> (sym_data == 5'd0 && !sym_clk));
endmodule

bind nrzi_symbol_rx nrzi_symbol_rx_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_en   (pwr_en),
    .sym_clk  (sym_clk),
    .sym_data (sym_data)
);

// File: tb/test_nrzi_symbol_rx.sv
`timescale 1ns/1ps
module test_nrzi_symbol_rx;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       pwr_en;
    logic       loop_n;
    logic       line_nrzi;
    logic       loop_nrzi;
    logic       sym_clk;
    logic [4:0] sym_data;

    int         total = 0;
    int         bad   = 0;
    logic       level;
    logic [4:0] last_sym;

    localparam int NVEC = 10;
    localparam logic [4:0] VEC [NVEC] = '{
        5'b11111, 5'b00011, 5'b10001, 5'b00000, 5'b10101,
        5'b01010, 5'b00001, 5'b10000, 5'b01101, 5'b11110
    };

    always #2.5 clk = ~clk;

    nrzi_symbol_rx i_nrzi_symbol_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_en    (pwr_en),
        .loop_n    (loop_n),
        .line_nrzi (line_nrzi),
        .loop_nrzi (loop_nrzi),
        .sym_clk   (sym_clk),
        .sym_data  (sym_data)
    );

    task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // called at a negedge; drives one NRZI-encoded group, bit 0 first
    task automatic send_sym(input logic [4:0] s, input bit via_loop, input string req);
        for (int i = 0; i < 5; i++) begin
            level = level ^ s[i];
            if (via_loop) begin
                loop_nrzi = level;
                line_nrzi = ~line_nrzi;
            end else begin
                line_nrzi = level;
                loop_nrzi = ~loop_nrzi;
            end
            @(negedge clk);
            chk("R4 sym_clk level", {4'b0, sym_clk}, {4'b0, (i >= 1 && i <= 3)});
            if (i < 4)
                chk("R3 hold mid-group", sym_data, last_sym);
        end
        chk({req, " R1 R2 symbol"}, sym_data, s);
        last_sym = s;
    endtask

    initial begin
        #(200000 * 5);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pwr_en = 1'b1; loop_n = 1'b1;
        line_nrzi = 1'b0; loop_nrzi = 1'b0;
        level = 1'b0; last_sym = 5'd0;
        repeat (3) @(negedge clk);
        chk("R8 reset data", sym_data, 5'd0);
        chk("R8 reset clock", {4'b0, sym_clk}, 5'd0);
        rst_n = 1'b1;

        for (int v = 0; v < NVEC; v++)
            send_sym(VEC[v], 1'b0, "R6 line path");

        // loopback: line input toggles as noise
        loop_n = 1'b0;
        send_sym(5'b11000, 1'b1, "R5 loopback");
        send_sym(5'b00111, 1'b1, "R5 loopback");
        send_sym(5'b11111, 1'b1, "R5 loopback");
        loop_n = 1'b1;
        send_sym(5'b01001, 1'b0, "R6 back to line");

        // power-down
        pwr_en = 1'b0;
        @(negedge clk);
        chk("R7 pd data", sym_data, 5'd0);
        chk("R7 pd clock", {4'b0, sym_clk}, 5'd0);
        for (int k = 0; k < 6; k++) begin
            line_nrzi = ~line_nrzi;
            @(negedge clk);
            chk("R7 pd held", {sym_clk, sym_data[3:0]}, 5'd0);
        end
        pwr_en = 1'b1;
        level = 1'b0; last_sym = 5'd0;
        send_sym(5'b10011, 1'b0, "R7 restart");
        send_sym(5'b00110, 1'b0, "R7 second group");

        // asynchronous reset in mid-group
        line_nrzi = ~level; level = ~level;
        @(negedge clk);
        #1 rst_n = 1'b0;
        #0.5;
        chk("R8 async data", sym_data, 5'd0);
        chk("R8 async clock", {4'b0, sym_clk}, 5'd0);
        @(negedge clk);
        rst_n = 1'b1;
        line_nrzi = 1'b0;
        level = 1'b0; last_sym = 5'd0;
        send_sym(5'b11011, 1'b0, "R3 after reset");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule